// File: doc/BRIEF.md
# Three-Share Dual-Rail Codec with Poison Detection

This block sits at the boundary between ordinary binary data and a datapath that carries every bit as three XOR shares, each share in turn carried as a complementary pair of wires. On the way in, each bit of a plain word is split into three shares. Two of the shares are random bits taken from an on-chip bank of linear feedback shift registers, and the third share is chosen so that the three XOR back to the plain bit. Each share is then driven as a true rail and its inverse, so that one plain bit turns into six wires.

On the way out, a word of rail pairs coming back from the protected datapath is recombined into a plain word by XORing the true rails of the three shares. At the same time, each rail pair is checked by its Hamming weight. A pair of weight one is legal. A pair of weight zero is an erased (zeroized) value, and a pair of weight two is also illegal. The result is classified as fully legal, partly poisoned, or entirely zeroized, which tells the surrounding logic whether a fault corrupted the computation.

The mask generator advances on every clock. It can be given a new seed at run time, and a seed that would leave a register stuck at zero is replaced by a fixed nonzero value.

Top module: `tri_rail_codec`

## Requirements
- R1: While reset is high, and after it until the first strobe, enc_out, enc_valid, dec_out, dec_valid, all_zero, any_illegal and status are all zero.
- R2: Rail layout. For plain bit i and share k (k = 0, 1, 2), the true rail is at enc_out bit 6i+2k and its complement is at bit 6i+2k+1. One cycle after enc_start, every such pair holds opposite values.
- R3: One cycle after enc_start, enc_valid is high, and for every bit i the XOR of enc_out bits 6i, 6i+2 and 6i+4 equals bit i of the plain_in that was sampled with the strobe.
- R4: The masks advance on every clock, so two encodings of the same plain word on back-to-back cycles differ.
- R5: Loading a zero seed through seed_we/seed_in does not stop the masking. The share-0 true rails of plain bits 0 to 31 are not all zero in the encodings that follow.
- R6: The masks are a pure function of the seed. Loading the same seed and encoding the same word at the same cycle offset after the load gives an identical enc_out.
- R7: One cycle after rail_valid, dec_valid pulses high for a single cycle, and dec_out bit i equals the XOR of rail_in bits 6i, 6i+2 and 6i+4. dec_out and the flags hold until the next rail_valid.
- R8: all_zero is high exactly when every rail pair of the accepted rail_in is (0,0). status is then 2.
- R9: any_illegal is high when at least one pair is (0,0) or (1,1). status is 1 for an illegal word that is not fully zeroized, and 0 with both flags low when every pair is legal.
- R10: Feeding an enc_out word back into rail_in decodes to the original plain word, with status 0.
- R11: enc_out holds its value in every cycle without enc_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_we | input | 1 | Load seed_in into the mask generator |
| seed_in | input | 32 | New mask seed; zero is replaced by a constant |
| enc_start | input | 1 | Encode strobe for plain_in |
| plain_in | input | W | Plain word to encode |
| enc_out | output | 6W | Encoded rail word, three shares per bit, two rails per share |
| enc_valid | output | 1 | enc_out was updated by the previous strobe |
| rail_in | input | 6W | Rail word returning from the protected datapath |
| rail_valid | input | 1 | Accept rail_in for decoding and checking |
| dec_out | output | W | XOR recombination of the accepted rail word |
| dec_valid | output | 1 | One-cycle pulse: dec_out and flags refreshed |
| all_zero | output | 1 | Every rail pair was (0,0) |
| any_illegal | output | 1 | At least one rail pair was (0,0) or (1,1) |
| status | output | 2 | 0 legal, 1 partly poisoned, 2 zeroized |

## Verification
Consider first a fault in the mask bank, such as a register stuck at zero or a seed that is not applied. It does not change any decoded value. It only shows up as repeated share values across encodings, or as two runs from the same seed that do not match. For that reason the encodings are compared with each other, one cycle after each strobe, rather than only with the plain word. A fault in the share or rail wiring shows up on the very next enc_out, as a non-complementary pair or a wrong share XOR. A wrong pair classification shows up in the flags and status one cycle after rail_valid, so poisoned words with a single (0,0) pair, a single (1,1) pair and all pairs zeroized are each fed in, followed by a legal word to see the flags clear.

// File: rtl/trc_pkg.sv
package trc_pkg;

    // width of one mask generator lane
    localparam int LANE_W = 32;
    // feedback mask of the right-shifting lane register
    localparam logic [LANE_W-1:0] LANE_POLY  = 32'hB4BC_D35C;
    // substitute for a seed that would lock a lane at zero
    localparam logic [LANE_W-1:0] ZERO_SUB   = 32'h6A09_E667;
    // spreads one seed across lanes
    localparam logic [LANE_W-1:0] LANE_SPRD  = 32'h9E37_79B9;
    // shares per plain bit and rails per share
    localparam int SHARES  = 3;
    localparam int RAILS   = 2;
    localparam int GROUP_W = SHARES * RAILS;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_PARTIAL  = 2'd1,
        ST_ZEROIZED = 2'd2
    } poison_e;

    // true rail in the low position, complement above it
    typedef struct packed {
        logic f_rail;
        logic t_rail;
    } rail_pair_t;

    // share 0 in the low pair
    typedef struct packed {
        rail_pair_t sh2;
        rail_pair_t sh1;
        rail_pair_t sh0;
    } bit_group_t;

    function automatic logic [LANE_W-1:0] lane_step(input logic [LANE_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LANE_POLY : '0);
    endfunction

    function automatic logic [LANE_W-1:0] lane_seed(input logic [LANE_W-1:0] seed,
                                                    input int idx);
        logic [LANE_W-1:0] m;
        m = seed ^ LANE_W'(LANE_SPRD * LANE_W'(idx));
        return (m == '0) ? ZERO_SUB : m;
    endfunction

    function automatic rail_pair_t make_pair(input logic v);
        rail_pair_t p;
        p.t_rail = v;
        p.f_rail = ~v;
        return p;
    endfunction

    // Hamming weight of one pair: 1 legal, 0 erased, 2 illegal
    function automatic logic [1:0] pair_weight(input rail_pair_t p);
        return {1'b0, p.t_rail} + {1'b0, p.f_rail};
    endfunction

endpackage

// File: rtl/trc_mask_gen.sv
module trc_mask_gen
    import trc_pkg::*;
#(
    parameter int MASK_W = 192,
    parameter logic [LANE_W-1:0] RESET_SEED = 32'hC0FF_EE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_we,
    input  logic [LANE_W-1:0] seed_in,
    output logic [MASK_W-1:0] mask
);
    localparam int LANES = (MASK_W + LANE_W - 1) / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] st;

        always_ff @(posedge clk) begin
            if (rst)
                st <= lane_seed(RESET_SEED, g);
            else if (seed_we)
                st <= lane_seed(seed_in, g);
            else
                st <= lane_step(st);
        end

        if ((g + 1) * LANE_W <= MASK_W) begin : g_full
            assign mask[g*LANE_W +: LANE_W] = st;
        end else begin : g_part
            localparam int REM = MASK_W - g * LANE_W;
            assign mask[g*LANE_W +: REM] = st[REM-1:0];
        end
    end

endmodule

// File: rtl/trc_share_enc.sv
module trc_share_enc
    import trc_pkg::*;
#(
    parameter int W = 96
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [W-1:0]         plain,
    input  logic [2*W-1:0]       mask,
    output logic [GROUP_W*W-1:0] rails,
    output logic                 valid
);
    localparam int RW = GROUP_W * W;

    bit_group_t grp [W];
    logic [RW-1:0] rails_nx;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            logic s0, s1, s2;
            s0 = mask[i];
            s1 = mask[W+i];
            s2 = plain[i] ^ s0 ^ s1;
            grp[i].sh0 = make_pair(s0);
            grp[i].sh1 = make_pair(s1);
            grp[i].sh2 = make_pair(s2);
        end
    end

    always_comb begin
        rails_nx = '0;
        for (int i = 0; i < W; i++)
            rails_nx[i*GROUP_W +: GROUP_W] = grp[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rails <= '0;
            valid <= 1'b0;
        end else begin
            valid <= start;
            if (start)
                rails <= rails_nx;
        end
    end

endmodule

// File: rtl/trc_rail_dec.sv
module trc_rail_dec
    import trc_pkg::*;
#(
    parameter int W = 96
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [GROUP_W*W-1:0] rails,
    output logic [W-1:0]         word,
    output logic                 all_zero,
    output logic                 any_illegal,
    output poison_e              status,
    output logic                 valid
);
    localparam int NPAIR = SHARES * W;

    bit_group_t        grp [W];
    logic [W-1:0]      word_nx;
    logic [NPAIR-1:0]  legal_v;
    logic [NPAIR-1:0]  erased_v;
    logic              az_nx, ill_nx;
    poison_e           st_nx;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            grp[i] = rails[i*GROUP_W +: GROUP_W];
            word_nx[i] = grp[i].sh0.t_rail ^ grp[i].sh1.t_rail ^ grp[i].sh2.t_rail;
            legal_v[3*i]    = (pair_weight(grp[i].sh0) == 2'd1);
            legal_v[3*i+1]  = (pair_weight(grp[i].sh1) == 2'd1);
            legal_v[3*i+2]  = (pair_weight(grp[i].sh2) == 2'd1);
            erased_v[3*i]   = (pair_weight(grp[i].sh0) == 2'd0);
            erased_v[3*i+1] = (pair_weight(grp[i].sh1) == 2'd0);
            erased_v[3*i+2] = (pair_weight(grp[i].sh2) == 2'd0);
        end
    end

    always_comb begin
        az_nx  = &erased_v;
        ill_nx = ~&legal_v;
        if (az_nx)
            st_nx = ST_ZEROIZED;
        else if (ill_nx)
            st_nx = ST_PARTIAL;
        else
            st_nx = ST_CLEAN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word        <= '0;
            all_zero    <= 1'b0;
            any_illegal <= 1'b0;
            status      <= ST_CLEAN;
            valid       <= 1'b0;
        end else begin
            valid <= in_valid;
            if (in_valid) begin
                word        <= word_nx;
                all_zero    <= az_nx;
                any_illegal <= ill_nx;
                status      <= st_nx;
            end
        end
    end

endmodule

// File: rtl/tri_rail_codec.sv
module tri_rail_codec
    import trc_pkg::*;
#(
    parameter int W = 96,
    parameter logic [LANE_W-1:0] RESET_SEED = 32'hC0FF_EE01
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seed_we,
    input  logic [LANE_W-1:0]    seed_in,
    input  logic                 enc_start,
    input  logic [W-1:0]         plain_in,
    output logic [GROUP_W*W-1:0] enc_out,
    output logic                 enc_valid,
    input  logic [GROUP_W*W-1:0] rail_in,
    input  logic                 rail_valid,
    output logic [W-1:0]         dec_out,
    output logic                 dec_valid,
    output logic                 all_zero,
    output logic                 any_illegal,
    output logic [1:0]           status
);
    localparam int MASK_W = 2 * W;

    logic [MASK_W-1:0] mask;
    poison_e           st_q;

    trc_mask_gen #(.MASK_W(MASK_W), .RESET_SEED(RESET_SEED)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .seed_we (seed_we),
        .seed_in (seed_in),
        .mask    (mask)
    );

    trc_share_enc #(.W(W)) u_enc (
        .clk   (clk),
        .rst   (rst),
        .start (enc_start),
        .plain (plain_in),
        .mask  (mask),
        .rails (enc_out),
        .valid (enc_valid)
    );

    trc_rail_dec #(.W(W)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (rail_valid),
        .rails       (rail_in),
        .word        (dec_out),
        .all_zero    (all_zero),
        .any_illegal (any_illegal),
        .status      (st_q),
        .valid       (dec_valid)
    );

    assign status = st_q;

endmodule

// File: rtl/trc_checker.sv
module trc_checker
    import trc_pkg::*;
#(
    parameter int W = 96
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 seed_we,
    input logic [LANE_W-1:0]    seed_in,
    input logic                 enc_start,
    input logic [W-1:0]         plain_in,
    input logic [GROUP_W*W-1:0] enc_out,
    input logic                 enc_valid,
    input logic [GROUP_W*W-1:0] rail_in,
    input logic                 rail_valid,
    input logic [W-1:0]         dec_out,
    input logic                 dec_valid,
    input logic                 all_zero,
    input logic                 any_illegal,
    input logic [1:0]           status
);
    logic         enc_pairs_ok;
    logic [W-1:0] enc_xor;
    logic [W-1:0] rail_xor;
    logic         seed_seen;

    always_comb begin
        enc_pairs_ok = 1'b1;
        for (int i = 0; i < W; i++) begin
            for (int k = 0; k < SHARES; k++)
                if (enc_out[GROUP_W*i+2*k] == enc_out[GROUP_W*i+2*k+1])
                    enc_pairs_ok = 1'b0;
            enc_xor[i]  = enc_out[GROUP_W*i] ^ enc_out[GROUP_W*i+2] ^ enc_out[GROUP_W*i+4];
            rail_xor[i] = rail_in[GROUP_W*i] ^ rail_in[GROUP_W*i+2] ^ rail_in[GROUP_W*i+4];
        end
        seed_seen = seed_we & (seed_in == '0);
    end

    // R2: encoded pairs are complementary whenever a fresh encoding is out
    assert_pairs_complement_R2: assert property (@(posedge clk) disable iff (rst)
        enc_valid |-> enc_pairs_ok);

    // R3: valid follows the strobe and the shares recombine to the plain word
    assert_enc_valid_R3: assert property (@(posedge clk) disable iff (rst)
        enc_start |=> enc_valid);
    assert_share_xor_R3: assert property (@(posedge clk) disable iff (rst)
        enc_start |=> (enc_xor == $past(plain_in)));

    // R11: no strobe, no change
    assert_enc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !enc_start |=> $stable(enc_out));

    // R7: decode latency, pulse width and value
    assert_dec_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rail_valid |=> dec_valid);
    assert_dec_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !rail_valid |=> !dec_valid);
    assert_dec_value_R7: assert property (@(posedge clk) disable iff (rst)
        rail_valid |=> (dec_out == $past(rail_xor)));
    assert_dec_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rail_valid |=> $stable(dec_out) && $stable(status));

    // R8: a zeroized word is also illegal and reported as such
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        all_zero |-> (any_illegal && status == 2'd2));

    // R9: status agrees with the flags
    assert_partial_R9: assert property (@(posedge clk) disable iff (rst)
        (any_illegal && !all_zero) |-> (status == 2'd1));
    assert_clean_R9: assert property (@(posedge clk) disable iff (rst)
        !any_illegal |-> (status == 2'd0 && !all_zero));

    // R5: after a zero seed the next encoding still carries complementary pairs
    assert_zero_seed_R5: assert property (@(posedge clk) disable iff (rst)
        (seed_seen && enc_start) |=> enc_pairs_ok);

endmodule

bind tri_rail_codec trc_checker #(.W(W)) u_chk (.*);

// File: tb/sim_tri_rail_codec.sv
module sim_tri_rail_codec;
    import trc_pkg::*;

    localparam int W     = 40;
    localparam int RW    = GROUP_W * W;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              seed_we = 1'b0;
    logic [LANE_W-1:0] seed_in = '0;
    logic              enc_start = 1'b0;
    logic [W-1:0]      plain_in = '0;
    logic [RW-1:0]     enc_out;
    logic              enc_valid;
    logic [RW-1:0]     rail_in = '0;
    logic              rail_valid = 1'b0;
    logic [W-1:0]      dec_out;
    logic              dec_valid;
    logic              all_zero;
    logic              any_illegal;
    logic [1:0]        status;

    always #(CLK_P/2) clk = ~clk;

    tri_rail_codec #(.W(W)) u0 (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_in(seed_in),
        .enc_start(enc_start), .plain_in(plain_in), .enc_out(enc_out),
        .enc_valid(enc_valid), .rail_in(rail_in), .rail_valid(rail_valid),
        .dec_out(dec_out), .dec_valid(dec_valid), .all_zero(all_zero),
        .any_illegal(any_illegal), .status(status)
    );

    typedef struct packed {
        logic [W-1:0] word;
        logic         az;
        logic         ill;
        logic [1:0]   st;
    } dexp_t;

    int            n_chk  = 0;
    int            n_fail = 0;
    logic [W-1:0]  enc_q   [$];
    logic [RW-1:0] enc_log [$];
    dexp_t         dec_q   [$];
    logic [W-1:0]  last_word;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // layout from R2: share k of bit i, true rail at 6i+2k, complement above
    function automatic logic [RW-1:0] build_rails(input logic [W-1:0] p,
                                                  input logic [W-1:0] m0,
                                                  input logic [W-1:0] m1);
        logic [RW-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            logic s2;
            s2 = p[i] ^ m0[i] ^ m1[i];
            r[6*i]   = m0[i]; r[6*i+1] = ~m0[i];
            r[6*i+2] = m1[i]; r[6*i+3] = ~m1[i];
            r[6*i+4] = s2;    r[6*i+5] = ~s2;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] true_xor(input logic [RW-1:0] r);
        logic [W-1:0] x;
        for (int i = 0; i < W; i++)
            x[i] = r[6*i] ^ r[6*i+2] ^ r[6*i+4];
        return x;
    endfunction

    function automatic bit pairs_ok(input logic [RW-1:0] r);
        bit ok;
        ok = 1'b1;
        for (int j = 0; j < 3*W; j++)
            if (r[2*j] == r[2*j+1]) ok = 1'b0;
        return ok;
    endfunction

    function automatic dexp_t model(input logic [RW-1:0] r);
        dexp_t e;
        int nz, nl;
        nz = 0; nl = 0;
        for (int j = 0; j < 3*W; j++) begin
            if (r[2*j] == 1'b0 && r[2*j+1] == 1'b0) nz++;
            if (r[2*j] != r[2*j+1]) nl++;
        end
        e.word = true_xor(r);
        e.az   = (nz == 3*W);
        e.ill  = (nl != 3*W);
        e.st   = e.az ? 2'd2 : (e.ill ? 2'd1 : 2'd0);
        return e;
    endfunction

    function automatic logic [31:0] share0_low(input logic [RW-1:0] r);
        logic [31:0] s;
        for (int i = 0; i < 32; i++)
            s[i] = r[6*i];
        return s;
    endfunction

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (enc_valid) begin
                if (enc_q.size() == 0) begin
                    check(1'b0, "R3", "enc_valid with nothing pending", 1, 0);
                end else begin
                    logic [W-1:0] p;
                    p = enc_q.pop_front();
                    enc_log.push_back(enc_out);
                    check(pairs_ok(enc_out), "R2", "rail pairs complementary", enc_out, 0);
                    check(true_xor(enc_out) == p, "R3", "share xor", true_xor(enc_out), p);
                end
            end
            if (dec_valid) begin
                if (dec_q.size() == 0) begin
                    check(1'b0, "R7", "dec_valid with nothing pending", 1, 0);
                end else begin
                    dexp_t e;
                    e = dec_q.pop_front();
                    check(dec_out == e.word, "R7", "dec_out", dec_out, e.word);
                    check(all_zero == e.az, "R8", "all_zero", all_zero, e.az);
                    check(any_illegal == e.ill, "R9", "any_illegal", any_illegal, e.ill);
                    check(status == e.st, "R9", "status", status, e.st);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_enc(input logic [W-1:0] p);
        enc_start = 1'b1;
        plain_in  = p;
        enc_q.push_back(p);
        @(negedge clk);
        enc_start = 1'b0;
    endtask

    task automatic do_dec_exp(input logic [RW-1:0] r, input dexp_t e);
        rail_valid = 1'b1;
        rail_in    = r;
        dec_q.push_back(e);
        last_word  = e.word;
        @(negedge clk);
        rail_valid = 1'b0;
    endtask

    task automatic do_dec(input logic [RW-1:0] r);
        do_dec_exp(r, model(r));
    endtask

    task automatic load_seed(input logic [LANE_W-1:0] s);
        seed_we = 1'b1;
        seed_in = s;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int b;
        logic [RW-1:0] r, e1;
        dexp_t ex;

        // R1: state under reset
        idle(3);
        check(enc_out == '0 && !enc_valid && dec_out == '0 && !dec_valid &&
              !all_zero && !any_illegal && status == 2'd0,
              "R1", "outputs under reset", {enc_valid, dec_valid, all_zero, any_illegal, status}, 0);
        rst = 1'b0;
        idle(1);
        check(enc_out == '0 && !enc_valid && status == 2'd0, "R1", "outputs after reset",
              {enc_valid, status}, 0);

        // R2, R3: several plain patterns
        do_enc('0);
        do_enc('1);
        do_enc(40'hA5_5A3C_C3F0);
        do_enc(40'h12_3456_789A);
        idle(2);

        // R4: back-to-back encodings of the same word
        b = enc_log.size();
        do_enc(40'h0F_F00F_F00F);
        do_enc(40'h0F_F00F_F00F);
        idle(2);
        check(enc_log[b] != enc_log[b+1], "R4", "repeat encoding differs", enc_log[b], enc_log[b+1]);

        // R11: held without strobe
        idle(3);
        check(enc_out == enc_log[b+1], "R11", "enc_out held", enc_out, enc_log[b+1]);

        // R6: same seed, same offset, same result
        load_seed(32'h1357_9BDF);
        idle(2);
        do_enc(40'hDE_ADBE_EF01);
        idle(2);
        e1 = enc_log[enc_log.size()-1];
        idle(5);
        load_seed(32'h1357_9BDF);
        idle(2);
        do_enc(40'hDE_ADBE_EF01);
        idle(2);
        check(enc_log[enc_log.size()-1] == e1, "R6", "reseeded encoding repeats",
              enc_log[enc_log.size()-1], e1);

        // R5: zero seed still masks
        load_seed('0);
        do_enc('0);
        do_enc('0);
        idle(2);
        b = enc_log.size();
        check(share0_low(enc_log[b-2]) != '0, "R5", "share0 after zero seed (1st)",
              share0_low(enc_log[b-2]), 1);
        check(share0_low(enc_log[b-1]) != '0, "R5", "share0 after zero seed (2nd)",
              share0_low(enc_log[b-1]), 1);

        // R7: legal words with varied masks
        do_dec(build_rails(40'h11_2233_4455, 40'hFF_0000_FFFF, 40'h0A_0B0C_0D0E));
        do_dec(build_rails(40'hFF_FFFF_FFFF, '0, '0));
        do_dec(build_rails('0, '1, 40'h55_AA55_AA55));

        // R8: fully zeroized
        do_dec('0);

        // R9: single (1,1) pair, then a single (0,0) pair, then clean again
        r = build_rails(40'hC0_FFEE_1234, 40'h33_3333_3333, 40'h0F_0F0F_0F0F);
        r[6*3+3 -: 2] = 2'b11;
        do_dec(r);
        r = build_rails(40'hC0_FFEE_1234, 40'h33_3333_3333, 40'h0F_0F0F_0F0F);
        r[6*39+5 -: 2] = 2'b00;
        do_dec(r);
        do_dec(build_rails(40'h98_7654_3210, 40'h12_1212_1212, 40'hE1_E1E1_E1E1));

        // R10: loopback of two encoded words
        ex.word = 40'h12_3456_789A; ex.az = 1'b0; ex.ill = 1'b0; ex.st = 2'd0;
        do_dec_exp(enc_log[3], ex);
        ex.word = 40'hDE_ADBE_EF01;
        do_dec_exp(e1, ex);

        // R7: pulse width and hold
        idle(3);
        check(!dec_valid, "R7", "dec_valid returns low", dec_valid, 0);
        check(dec_out == last_word && status == 2'd0, "R7", "dec_out held", dec_out, last_word);

        idle(2);
        check(enc_q.size() == 0 && dec_q.size() == 0, "R7", "all results delivered",
              enc_q.size() + dec_q.size(), 0);

        summary();
        $finish;
    end

endmodule